// File: doc/BRIEF.md
# Boundary Scan Data Register with Update Latches

This block is the serial boundary-scan data register placed between the pins and the core of a bidirectional bus transceiver. Every cell holds two bits. One is a serial stage that captures a pin or core value and shifts toward the test data output. The other is an update latch that holds the value forced onto a pin or into the core while the test mode is selected. Dedicated input pins get one cell each. Every bidirectional pin gets two cells: one observes the level at the pin and forces the core-side receive value, and the other observes the core's transmit value and forces the pin.

The capture, shift and update strobes come already decoded from an external test access controller. A separate select picks between normal operation and the boundary test instruction. Capture and shift act on the rising test clock edge. The update latches, the serial output and its enable change on the falling edge. In normal operation, pins and core are wired straight through and the update latches have no effect on any output.

Top module: `bscan_chain`

## Requirements
- R1: An active-low asynchronous reset clears every serial stage and every update latch to 0, and deasserts the serial output enable.
- R2: The chain holds N = IN_PINS + 2*IO_PINS cells, so 84 by default. A bit entered at `tdi` reaches `tdo` after N shift edges.
- R3: Cell 0 is nearest `tdo`. Cells 0 to IN_PINS-1 belong to `in_pin[i]`. For bidirectional pin k, cell IN_PINS+2k is the receive cell and cell IN_PINS+2k+1 is the transmit cell.
- R4: On a rising edge with `cap_en` high, input and receive cells load the pin levels (`in_pin`, `io_pin_rx`) and transmit cells load `io_core_tx`. Capture takes priority over shift.
- R5: On a rising edge with `shf_en` high and `cap_en` low, every cell takes the value of its higher-numbered neighbour, and cell N-1 takes `tdi`.
- R6: On a falling edge with `upd_en` high, every update latch copies its serial stage. On any other falling edge, the latches hold their value.
- R7: `tdo` and `tdo_en` change only on the falling edge. There, `tdo` takes cell 0 and `tdo_en` takes the level of `shf_en`, so the output returns to high impedance on the first falling edge after shifting ends.
- R8: With `test_mode` low, `core_in = in_pin`, `io_core_rx = io_pin_rx` and `io_pin_drv = io_core_tx`.
- R9: With `test_mode` high, `core_in`, `io_core_rx` and `io_pin_drv` come from the update latches of the matching cells.
- R10: On a rising edge with `cap_en` and `shf_en` both low, the serial stages keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial test data in |
| cap_en | input | 1 | Capture strobe, sampled on the rising edge |
| shf_en | input | 1 | Shift strobe, sampled on both edges |
| upd_en | input | 1 | Update strobe, sampled on the falling edge |
| test_mode | input | 1 | 1 selects boundary test outputs, 0 selects transparent |
| in_pin | input | IN_PINS | Levels at the dedicated input pins |
| core_in | output | IN_PINS | Values presented to the core for the dedicated inputs |
| io_pin_rx | input | IO_PINS | Levels at the bidirectional pins |
| io_core_tx | input | IO_PINS | Core transmit values for the bidirectional pins |
| io_core_rx | output | IO_PINS | Receive values presented to the core |
| io_pin_drv | output | IO_PINS | Values driven toward the bidirectional pins |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Serial output enable; 0 means high impedance |

## Verification
A wrong serial stage has no visible effect until it is shifted out. It then appears at `tdo` on the falling edge that follows the shift bringing it to cell 0, so a single scan of N cycles exposes any wrong capture mapping or wrong cell order. A wrong update latch shows on the forced outputs as soon as test mode is selected, which is one falling edge after an update. A wrong enable shows as `tdo_en` being wrong for the whole half-cycle after that falling edge. The reference model is compared against every output after each falling edge, so any such error is reported within one clock of the point where it first becomes visible.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int IN_PINS = 12,
  parameter int IO_PINS = 36
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tdi,
  input  logic               cap_en,
  input  logic               shf_en,
  input  logic               upd_en,
  input  logic               test_mode,
  input  logic [IN_PINS-1:0] in_pin,
  output logic [IN_PINS-1:0] core_in,
  input  logic [IO_PINS-1:0] io_pin_rx,
  input  logic [IO_PINS-1:0] io_core_tx,
  output logic [IO_PINS-1:0] io_core_rx,
  output logic [IO_PINS-1:0] io_pin_drv,
  output logic               tdo,
  output logic               tdo_en
);
  localparam int N = IN_PINS + 2 * IO_PINS;

  logic [N-1:0] sr, sh, cap_vec;
  logic [IO_PINS-1:0] sh_rx, sh_tx;

  assign cap_vec[IN_PINS-1:0] = in_pin;

  for (genvar k = 0; k < IO_PINS; k++) begin : g_io
    assign cap_vec[IN_PINS+2*k]   = io_pin_rx[k];
    assign cap_vec[IN_PINS+2*k+1] = io_core_tx[k];
    assign sh_rx[k] = sh[IN_PINS+2*k];
    assign sh_tx[k] = sh[IN_PINS+2*k+1];
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (cap_en) sr <= cap_vec;
    else if (shf_en) sr <= {tdi, sr[N-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      if (upd_en) sh <= sr;
      tdo    <= sr[0];
      tdo_en <= shf_en;
    end
  end

  assign core_in    = test_mode ? sh[IN_PINS-1:0] : in_pin;
  assign io_core_rx = test_mode ? sh_rx : io_pin_rx;
  assign io_pin_drv = test_mode ? sh_tx : io_core_tx;
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int IN_PINS = 12,
  parameter int IO_PINS = 36
) (
  input logic                           tck,
  input logic                           rst_n,
  input logic                           tdi,
  input logic                           cap_en,
  input logic                           shf_en,
  input logic                           upd_en,
  input logic                           test_mode,
  input logic [IN_PINS-1:0]             in_pin,
  input logic [IN_PINS-1:0]             core_in,
  input logic [IO_PINS-1:0]             io_pin_rx,
  input logic [IO_PINS-1:0]             io_core_tx,
  input logic [IO_PINS-1:0]             io_core_rx,
  input logic [IO_PINS-1:0]             io_pin_drv,
  input logic                           tdo,
  input logic                           tdo_en,
  input logic [IN_PINS+2*IO_PINS-1:0]   sr,
  input logic [IN_PINS+2*IO_PINS-1:0]   sh
);
  localparam int N = IN_PINS + 2 * IO_PINS;

  a_r5_shift_moves: assert property (@(posedge tck) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (sr[N-1] == $past(tdi)) && (sr[N-2:0] == $past(sr[N-1:1])));

  a_r10_serial_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!shf_en && !cap_en) |=> $stable(sr));

  a_r6_latch_hold: assert property (@(negedge tck) disable iff (!rst_n)
    !upd_en |=> $stable(sh));

  a_r6_latch_copy: assert property (@(negedge tck) disable iff (!rst_n)
    upd_en |=> (sh == $past(sr)));

  a_r7_enable_on: assert property (@(negedge tck) disable iff (!rst_n)
    shf_en |=> tdo_en);

  a_r7_enable_off: assert property (@(negedge tck) disable iff (!rst_n)
    !shf_en |=> !tdo_en);

  a_r8_transparent: assert property (@(negedge tck) disable iff (!rst_n)
    !test_mode |-> (core_in == in_pin) && (io_core_rx == io_pin_rx) && (io_pin_drv == io_core_tx));

  a_r9_forced: assert property (@(negedge tck) disable iff (!rst_n)
    test_mode |-> (core_in == sh[IN_PINS-1:0]) && (io_core_rx[0] == sh[IN_PINS])
                  && (io_pin_drv[0] == sh[IN_PINS+1]));
endmodule

bind bscan_chain bscan_chain_chk #(.IN_PINS(IN_PINS), .IO_PINS(IO_PINS)) u_chk (
  .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap_en(cap_en), .shf_en(shf_en),
  .upd_en(upd_en), .test_mode(test_mode), .in_pin(in_pin), .core_in(core_in),
  .io_pin_rx(io_pin_rx), .io_core_tx(io_core_tx), .io_core_rx(io_core_rx),
  .io_pin_drv(io_pin_drv), .tdo(tdo), .tdo_en(tdo_en), .sr(sr), .sh(sh)
);

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int CLK_PERIOD = 10;
  localparam int IN = 12;
  localparam int IO = 36;
  localparam int N  = IN + 2 * IO;

  logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0;
  logic cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0, test_mode = 1'b1;
  logic [IN-1:0] in_pin = '0, core_in;
  logic [IO-1:0] io_pin_rx = '0, io_core_tx = '0, io_core_rx, io_pin_drv;
  logic tdo, tdo_en;

  bscan_chain #(.IN_PINS(IN), .IO_PINS(IO)) u0 (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap_en(cap_en), .shf_en(shf_en),
    .upd_en(upd_en), .test_mode(test_mode), .in_pin(in_pin), .core_in(core_in),
    .io_pin_rx(io_pin_rx), .io_core_tx(io_core_tx), .io_core_rx(io_core_rx),
    .io_pin_drv(io_pin_drv), .tdo(tdo), .tdo_en(tdo_en));

  always #(CLK_PERIOD/2) tck = ~tck;

  int n_chk = 0, n_bad = 0;
  bit q[$];
  logic [IN-1:0] m_core;
  logic [IO-1:0] m_rx, m_tx;
  logic m_tdo, m_en;
  string phase = "R1";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete();
    for (int i = 0; i < N; i++) q.push_back(1'b0);
    m_core = '0; m_rx = '0; m_tx = '0; m_tdo = 1'b0; m_en = 1'b0;
  endtask

  task automatic model_neg();
    if (upd_en) begin
      for (int i = 0; i < IN; i++) m_core[i] = q[i];
      for (int k = 0; k < IO; k++) begin
        m_rx[k] = q[IN+2*k];
        m_tx[k] = q[IN+2*k+1];
      end
    end
    m_tdo = q[0];
    m_en  = shf_en;
  endtask

  task automatic model_pos();
    if (cap_en) begin
      for (int i = 0; i < IN; i++) q[i] = in_pin[i];
      for (int k = 0; k < IO; k++) begin
        q[IN+2*k]   = io_pin_rx[k];
        q[IN+2*k+1] = io_core_tx[k];
      end
    end else if (shf_en) begin
      void'(q.pop_front());
      q.push_back(tdi);
    end
  endtask

  task automatic compare();
    logic [IN-1:0] ec;
    logic [IO-1:0] er, et;
    string t;
    ec = test_mode ? m_core : in_pin;
    er = test_mode ? m_rx : io_pin_rx;
    et = test_mode ? m_tx : io_core_tx;
    t  = test_mode ? "R9/R6" : "R8";
    chk(core_in == ec, {t, " core_in ", phase}, 64'(core_in), 64'(ec));
    chk(io_core_rx == er, {t, " io_core_rx ", phase}, 64'(io_core_rx), 64'(er));
    chk(io_pin_drv == et, {t, " io_pin_drv ", phase}, 64'(io_pin_drv), 64'(et));
    chk(tdo_en == m_en, {"R7 tdo_en ", phase}, 64'(tdo_en), 64'(m_en));
    chk(tdo == m_tdo, {"R7 tdo ", phase}, 64'(tdo), 64'(m_tdo));
  endtask

  task automatic tick();
    @(negedge tck);
    model_neg();
    #1 compare();
    @(posedge tck);
    model_pos();
    #1;
  endtask

  task automatic rand_pins();
    in_pin     = IN'($urandom);
    io_pin_rx  = IO'({$urandom, $urandom});
    io_core_tx = IO'({$urandom, $urandom});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    rand_pins();
    #(CLK_PERIOD * 3);
    @(posedge tck);
    #1 rst_n = 1'b1;
    // R1: reset clears latches and output enable
    chk(core_in == '0, "R1 core_in after reset", 64'(core_in), 64'd0);
    chk(io_pin_drv == '0, "R1 io_pin_drv after reset", 64'(io_pin_drv), 64'd0);
    chk(tdo_en == 1'b0, "R1 tdo_en after reset", 64'(tdo_en), 64'd0);
    phase = "R1 serial cleared";
    shf_en = 1'b1; tdi = 1'b1;
    repeat (N) tick();
    shf_en = 1'b0;

    phase = "R8 normal mode";
    test_mode = 1'b0;
    for (int i = 0; i < 6; i++) begin rand_pins(); tick(); end

    for (int pass = 0; pass < 3; pass++) begin
      phase = "R4 capture R3 order";
      rand_pins();
      if (pass == 1) begin in_pin = '1; io_pin_rx = '0; io_core_tx = '1; end
      cap_en = 1'b1; shf_en = pass[0];
      tick();
      cap_en = 1'b0; shf_en = 1'b1;
      phase = "R5 shift R2 length";
      for (int i = 0; i < N; i++) begin tdi = 1'($urandom); tick(); end
      shf_en = 1'b0; upd_en = 1'b1; test_mode = 1'b1;
      phase = "R6 update";
      tick();
      upd_en = 1'b0;
      phase = "R10 hold R6 latch hold";
      for (int i = 0; i < 5; i++) begin rand_pins(); tick(); end
    end

    phase = "R2 walking one";
    shf_en = 1'b1; tdi = 1'b1;
    tick();
    tdi = 1'b0;
    for (int i = 0; i < N + 3; i++) tick();
    shf_en = 1'b0;
    phase = "R7 release";
    tick(); tick();

    phase = "R8 back to normal";
    test_mode = 1'b0; upd_en = 1'b1;
    for (int i = 0; i < 3; i++) begin rand_pins(); tick(); end
    upd_en = 1'b0;
    finish_run();
  end
endmodule